// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block gathers interrupt requests from a set of on-chip sources and hands one request, with a vector, to a processor. It holds one pending bit, one mask bit and one in-service bit per source. Each source is either pulse-driven or level-driven, as a build parameter selects. A pulse-driven source is a general-purpose pin or a simple timer. Its input is synchronized and edge-detected, and the resulting event latches a pending bit. A level-driven source is a peripheral with its own event register outside this block. The block sees only that register's masked summary, and the pending bit follows the summary directly.

A processor reads and writes the state through a small register port. It takes interrupts through an acknowledge strobe, which returns an 8-bit vector in the same cycle. A pulse-driven source drops its pending bit when it is acknowledged. A level-driven source stays pending until its peripheral summary falls. Either kind is then held off until software clears its in-service bit by writing a one. A level-driven source whose summary is still high requests again as soon as that bit clears.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all pending bits are 0, all in-service bits are 0, every mask bit is 1 (blocked), the vector base is 0, and `irq_o` is low.
- R2: On a pulse-driven source, a rising input sets its pending bit after the third rising clock edge that follows the input going high. Further rising edges while the bit is pending merge into that one bit.
- R3: An acknowledge that selects a pulse-driven source clears its pending bit. If a new synchronized rising edge for that source arrives in the same cycle, the bit stays set.
- R4: On a level-driven source, the pending bit equals `evt_level_i` for that source. An acknowledge does not clear it.
- R5: The mask register is at address 1, where a 1 blocks a source. A masked source still shows its pending bit but cannot raise `irq_o`. Clearing the mask bit lets the stored pending bit request in the same cycle.
- R6: `irq_o` is high exactly when some source is pending and unmasked, and no in-service bit is set at its own index or at any higher index. The highest index among such sources wins.
- R7: While `iack_i` is high and `irq_o` is high, `vec_o` equals {base[2:0], winner index in 5 bits}. At that clock edge the winner's in-service bit is set. An acknowledge while `irq_o` is low changes nothing.
- R8: The in-service register is at address 2. Writing 1 to a bit clears it, and writing 0 has no effect. A level-driven source that is still high requests again in the cycle after its bit clears.
- R9: The pending register is at address 0. Writing 1 clears the pending bit of a pulse-driven source. Writes to the bits of level-driven sources have no effect.
- R10: The vector base is at address 3, in bits [2:0]. On reads, every bit of the register port above a register's width returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse_i | input | N_SRC | Raw event inputs of pulse-driven sources (asynchronous) |
| evt_level_i | input | N_SRC | Masked event summaries of level-driven sources (synchronous) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 pending, 1 mask, 2 in-service, 3 base |
| reg_wdata_i | input | N_SRC | Register write data |
| reg_rdata_o | output | N_SRC | Register read data for `reg_addr_i` (combinational) |
| iack_i | input | 1 | Interrupt acknowledge strobe |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 8 | Vector of the current winner |

## Verification
Single pulses and back-to-back pulses on one pulse-driven source separate proper edge merging from double counting. A pulse timed so that its edge lands on the acknowledge cycle shows whether set or clear takes precedence. Level summaries that stay high through acknowledge and in-service clear show whether the two pending kinds are kept apart and whether a request comes back at once. Overlapping sources at different indices, with masks and in-service bits set at various levels, expose errors in priority order and in blocking at equal versus higher index. A long random mix of pulses, levels, writes and acknowledges is then checked every cycle against a behavioural model.

// File: rtl/irq_pkg.sv
// Shared definitions for the prioritized interrupt controller.
// Assumes a 2-bit register address space.
package irq_pkg;
    typedef enum logic [1:0] {
        ADDR_PEND = 2'd0,
        ADDR_MASK = 2'd1,
        ADDR_INSV = 2'd2,
        ADDR_BASE = 2'd3
    } irq_addr_e;
endpackage

// File: rtl/irq_edge_sync.sv
// Per-source synchronizer and rising-edge detector.
// Assumes each raw input stays high for at least one clock so it is seen.
// rise_o[i] is high for one cycle, STAGES edges after the input rises.
module irq_edge_sync #(
    parameter int N      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] rise_o
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic [STAGES:0] sh_q;

        // Shift the raw input through the sync chain plus one history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-1:0], raw_i[i]};
        end

        assign rise_o[i] = sh_q[STAGES-1] & ~sh_q[STAGES];
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: the highest set request index wins.
// Assumes N >= 2. idx_o is 0 when no request is set.
module irq_prio_pick #(
    parameter int N     = 16,
    parameter int SEL_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [SEL_W-1:0] idx_o
);
    // Scan upward so the last (highest) set index is kept.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = SEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Prioritized interrupt controller with pending, mask and in-service bits.
// MULTI_SRC marks level-driven sources; the others are pulse-driven.
// Assumes evt_level_i is synchronous to clk, and N_SRC <= 2**IDX_W.
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int               N_SRC       = 16,
    parameter logic [N_SRC-1:0] MULTI_SRC   = 16'hF0F0,
    parameter int               SYNC_STAGES = 2,
    parameter int               BASE_W      = 3,
    parameter int               IDX_W       = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        evt_pulse_i,
    input  logic [N_SRC-1:0]        evt_level_i,
    input  logic                    reg_wr_i,
    input  logic [1:0]              reg_addr_i,
    input  logic [N_SRC-1:0]        reg_wdata_i,
    output logic [N_SRC-1:0]        reg_rdata_o,
    input  logic                    iack_i,
    output logic                    irq_o,
    output logic [BASE_W+IDX_W-1:0] vec_o
);
    localparam int SEL_W = $clog2(N_SRC);

    logic [N_SRC-1:0]  pend_q, mask_q, isr_q;
    logic [BASE_W-1:0] base_q;
    logic [N_SRC-1:0]  rise, pend_all, blocked, elig;
    logic [N_SRC-1:0]  ack_hot, pend_clr, isr_clr;
    logic [SEL_W-1:0]  win_idx;
    logic              irq_any, ack_fire;
    irq_addr_e         addr;

    assign addr = irq_addr_e'(reg_addr_i);

    irq_edge_sync #(.N(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (evt_pulse_i),
        .rise_o (rise)
    );

    // Visible pending: latched for pulse sources, live summary for level sources.
    assign pend_all = (pend_q & ~MULTI_SRC) | (evt_level_i & MULTI_SRC);

    // A source is blocked by any in-service bit at its own or a higher index.
    for (genvar i = 0; i < N_SRC; i++) begin : g_blk
        assign blocked[i] = |isr_q[N_SRC-1:i];
    end

    assign elig = pend_all & ~mask_q & ~blocked;

    irq_prio_pick #(.N(N_SRC), .SEL_W(SEL_W)) u_pick (
        .req_i (elig),
        .any_o (irq_any),
        .idx_o (win_idx)
    );

    assign ack_fire = iack_i & irq_any;

    // Decode the acknowledge and the write-one-to-clear masks.
    always_comb begin
        ack_hot  = '0;
        if (ack_fire) ack_hot[win_idx] = 1'b1;
        pend_clr = ack_hot;
        if (reg_wr_i && addr == ADDR_PEND) pend_clr = pend_clr | reg_wdata_i;
        isr_clr  = '0;
        if (reg_wr_i && addr == ADDR_INSV) isr_clr = reg_wdata_i;
    end

    // Pulse-source pending bits: a new edge wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= ((pend_q & ~pend_clr) | rise) & ~MULTI_SRC;
    end

    // In-service bits: clear by writing one, set by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~isr_clr) | ack_hot;
    end

    // Mask register, all sources blocked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                             mask_q <= '1;
        else if (reg_wr_i && addr == ADDR_MASK) mask_q <= reg_wdata_i;
    end

    // Vector base register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             base_q <= '0;
        else if (reg_wr_i && addr == ADDR_BASE) base_q <= reg_wdata_i[BASE_W-1:0];
    end

    // Combinational register read mux.
    always_comb begin
        unique case (addr)
            ADDR_PEND: reg_rdata_o = pend_all;
            ADDR_MASK: reg_rdata_o = mask_q;
            ADDR_INSV: reg_rdata_o = isr_q;
            default:   reg_rdata_o = {{(N_SRC-BASE_W){1'b0}}, base_q};
        endcase
    end

    assign irq_o = irq_any;
    assign vec_o = {base_q, IDX_W'(win_idx)};

    // R7
    ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> isr_q[$past(win_idx)]);

    // R3
    single_ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !MULTI_SRC[win_idx] && !rise[win_idx]) |=> !pend_q[$past(win_idx)]);

    // R7
    isr_one_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr_q & ~$past(isr_q)));

    // R8
    isr_only_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((isr_q & ~$past(isr_q)) != '0) |-> $past(ack_fire));

    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_all & ~mask_q) == '0) |-> !irq_o);
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam bit [15:0] MULTI = 16'hF0F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pulse = '0, lvl = '0, wdata = '0;
    logic        wr = 1'b0, iack = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] rdata;
    logic        irq;
    logic [7:0]  vec;

    int nchk = 0, nerr = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit [15:0] m_pend, m_mask, m_isr, m_s1, m_s2, m_s3;
    bit [2:0]  m_base;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .evt_pulse_i(pulse), .evt_level_i(lvl),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .iack_i(iack), .irq_o(irq), .vec_o(vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit [15:0] m_pall();
        return (m_pend & ~MULTI) | (lvl & MULTI);
    endfunction

    function automatic int m_win();
        bit [15:0] p = m_pall();
        bit blk = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            if (m_isr[i]) blk = 1'b1;
            if (p[i] && !m_mask[i] && !blk) return i;
        end
        return -1;
    endfunction

    function automatic bit [15:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_pall();
            2'd1: return m_mask;
            2'd2: return m_isr;
            default: return {13'd0, m_base};
        endcase
    endfunction

    // reference model update on each clock edge
    always @(posedge clk) begin
        int w;
        bit [15:0] ack, clr, rise;
        if (!rst_n) begin
            m_pend <= '0; m_mask <= '1; m_isr <= '0; m_base <= '0;
            m_s1 <= '0; m_s2 <= '0; m_s3 <= '0;
        end else begin
            w = m_win();
            ack = '0;
            if (iack && w >= 0) ack[w] = 1'b1;
            rise = m_s2 & ~m_s3;
            clr = ack | ((wr && addr == 2'd0) ? wdata : 16'h0);
            m_s1 <= pulse; m_s2 <= m_s1; m_s3 <= m_s2;
            m_pend <= ((m_pend & ~clr) | rise) & ~MULTI;
            m_isr <= (m_isr & ~((wr && addr == 2'd2) ? wdata : 16'h0)) | ack;
            if (wr && addr == 2'd1) m_mask <= wdata;
            if (wr && addr == 2'd3) m_base <= wdata[2:0];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // compare outputs against the model after every edge
    task automatic compare();
        int w = m_win();
        logic [15:0] er = m_read(addr);
        chk(irq === (w >= 0), "R6 irq_o", 32'(irq), 32'(w >= 0));
        if (w >= 0) chk(vec === {m_base, 5'(w)}, "R7 vec_o", 32'(vec), 32'({m_base, 5'(w)}));
        chk(rdata === er, (addr == 0) ? "R2 pend read" : (addr == 1) ? "R5 mask read" :
            (addr == 2) ? "R8 isr read" : "R10 base read", 32'(rdata), 32'(er));
    endtask

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (rst_n) compare();
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [15:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0;
    endtask

    task automatic rchk(input logic [1:0] a, input logic [15:0] exp, input string tag);
        addr = a; #1;
        chk(rdata === exp, tag, 32'(rdata), 32'(exp));
    endtask

    task automatic ack_chk(input logic [7:0] exp_vec, input string tag);
        iack = 1'b1; #1;
        chk(irq === 1'b1 && vec === exp_vec, tag, 32'(vec), 32'(exp_vec));
        tick();
        iack = 1'b0;
    endtask

    task automatic pulse_src(input int s);
        pulse[s] = 1'b1; tick(); pulse[s] = 1'b0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        rchk(2'd0, 16'h0000, "R1 pend reset");
        rchk(2'd1, 16'hFFFF, "R1 mask reset");
        rchk(2'd2, 16'h0000, "R1 isr reset");
        rchk(2'd3, 16'h0000, "R1 base reset");
        chk(irq === 1'b0, "R1 irq reset", 32'(irq), 0);

        // R10 base and upper-bit zero
        wreg(2'd3, 16'hFFFD);
        rchk(2'd3, 16'h0005, "R10 base readback");
        wreg(2'd1, 16'h0000);

        // R2 pulse latency and merging
        pulse_src(2);
        tick();
        chk(irq === 1'b0, "R2 not yet pending", 32'(irq), 0);
        tick();
        chk(irq === 1'b1, "R2 pending after third edge", 32'(irq), 1);
        pulse_src(2);
        tick(4);
        ack_chk(8'hA2, "R7 vector src2");
        rchk(2'd0, 16'h0000, "R2 merged pulses single pending");
        rchk(2'd2, 16'h0004, "R7 isr set src2");
        wreg(2'd2, 16'h0000);
        rchk(2'd2, 16'h0004, "R8 write zero keeps isr");
        wreg(2'd2, 16'h0004);
        rchk(2'd2, 16'h0000, "R8 w1c isr");

        // R4 level source, R8 re-request
        lvl[4] = 1'b1; #1;
        chk(irq === 1'b1 && vec === 8'hA4, "R4 level request", 32'(vec), 32'hA4);
        tick();
        ack_chk(8'hA4, "R7 vector src4");
        rchk(2'd0, 16'h0010, "R4 level stays pending");
        chk(irq === 1'b0, "R6 self blocked", 32'(irq), 0);
        wreg(2'd2, 16'h0010);
        chk(irq === 1'b1, "R8 immediate re-request", 32'(irq), 1);
        lvl[4] = 1'b0; #1;
        chk(irq === 1'b0, "R4 level dropped", 32'(irq), 0);
        tick();

        // R6 priority and blocking by higher in-service
        pulse_src(3);
        tick(2);
        lvl[12] = 1'b1; #1;
        chk(vec === 8'hAC, "R6 highest wins", 32'(vec), 32'hAC);
        tick();
        ack_chk(8'hAC, "R7 vector src12");
        lvl[12] = 1'b0; #1;
        chk(irq === 1'b0, "R6 lower blocked by higher isr", 32'(irq), 0);
        tick();
        wreg(2'd2, 16'h1000);
        chk(irq === 1'b1 && vec === 8'hA3, "R6 lower released", 32'(vec), 32'hA3);
        ack_chk(8'hA3, "R7 vector src3");
        wreg(2'd2, 16'h0008);

        // R5 mask
        wreg(2'd1, 16'h0002);
        pulse_src(1);
        tick(3);
        rchk(2'd0, 16'h0002, "R5 masked still pending");
        chk(irq === 1'b0, "R5 masked no irq", 32'(irq), 0);
        wreg(2'd1, 16'h0000);
        chk(irq === 1'b1 && vec === 8'hA1, "R5 unmask requests", 32'(vec), 32'hA1);

        // R9 pending w1c
        lvl[4] = 1'b1;
        wreg(2'd0, 16'h0012);
        rchk(2'd0, 16'h0010, "R9 w1c single only");
        lvl[4] = 1'b0;
        tick();

        // R7 ack with no request
        iack = 1'b1; tick(); iack = 1'b0;
        rchk(2'd2, 16'h0000, "R7 idle ack no effect");

        // R3 edge coinciding with ack keeps pending
        pulse_src(0);
        tick(3);
        pulse[0] = 1'b1; tick(); pulse[0] = 1'b0; tick();
        ack_chk(8'hA0, "R7 vector src0");
        rchk(2'd0, 16'h0001, "R3 same-cycle edge wins");
        wreg(2'd2, 16'h0001);
        chk(irq === 1'b1, "R3 re-request src0", 32'(irq), 1);
        ack_chk(8'hA0, "R3 second ack");
        rchk(2'd0, 16'h0000, "R3 ack clears pulse source");
        wreg(2'd2, 16'h0001);

        // random mix checked by the model every cycle
        for (int c = 0; c < 4000; c++) begin
            pulse = 16'($urandom) & 16'($urandom) & 16'($urandom);
            if (($urandom % 8) == 0) lvl = 16'($urandom) & MULTI;
            iack = (($urandom % 4) == 0);
            wr = (($urandom % 5) == 0);
            addr = 2'($urandom);
            wdata = 16'($urandom) & ((addr == 2'd1) ? 16'h0F0F : 16'hFFFF);
            tick();
        end
        wr = 1'b0; iack = 1'b0; pulse = '0;
        tick(4);
        report();
    end
endmodule